// File: doc/BRIEF.md
# I/Q Sample Interleaving Bridge

This block joins an 8-bit parallel byte port on a host controller to a pair of baseband converters: an ADC that delivers I and Q samples, and a DAC that accepts them. The block runs from one clock at the host byte rate, which is twice the converter sample rate. Consecutive clock cycles form alternating Q and I slots, and each Q slot followed by its I slot carries one sample pair. In receive, each ADC byte captured in a slot is handed to the host one clock later. In transmit, each host byte is placed on the upper bits of the 10-bit DAC word one clock later, and the two low bits are zero.

Host inputs choose the direction, turn the stream on or off, and request Q inversion. The direction and stream-off inputs are sampled only between pairs, so a pair that has started always completes. While the stream is stopped the DAC sees mid-scale, the host byte output is zero and the qualifier output is low.

Top module: `iqb_bridge`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block enters its idle state: host_rx_o = 0, rx_valid_o = 0, dac_data_o = 10'h200 (mid-scale), slot_o = 0, the stream is stopped and the mode is receive.
- R2: While the stream runs, slots alternate between Q and I on every clock, and the first slot after a start is Q. slot_o reports the slot of the data on the outputs, with 0 for Q and 1 for I, and it is 0 whenever rx_valid_o is low.
- R3: In a receive slot, the adc_data_i value sampled at a clock edge appears on host_rx_o after the next edge.
- R4: In a transmit slot, the host_tx_i value sampled at a clock edge appears on dac_data_o[9:2] after the next edge, and dac_data_o[1:0] is always 0.
- R5: When q_flip_i is high in a Q slot, the byte passed on is the bitwise complement of the input in both directions. I slots are never changed.
- R6: While the stream is stopped, host_rx_o = 0 and dac_data_o = 10'h200.
- R7: stream_off_i and tx_mode_i are sampled only when the stream is stopped or at the edge that ends an I slot. A change during a Q slot has no effect until the pair completes.
- R8: rx_valid_o is high exactly for the slots that carry data, in either direction. In transmit, host_rx_o = 0. In receive, dac_data_o = 10'h200.
- R9: tx_mode_i high selects transmit (host to DAC). tx_mode_i low selects receive (ADC to host).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte-rate clock, twice the converter rate |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| stream_off_i | input | 1 | 1 = stop the sample stream |
| q_flip_i | input | 1 | 1 = complement Q samples |
| adc_data_i | input | 8 | Interleaved ADC sample byte |
| host_tx_i | input | 8 | Host byte for the DAC |
| host_rx_o | output | 8 | Sample byte to the host |
| rx_valid_o | output | 1 | Qualifier: slot carries data |
| slot_o | output | 1 | Slot of the output data (0 = Q, 1 = I) |
| dac_data_o | output | 10 | DAC word, low two bits zero |

## Verification
The bench changes direction and stream-off during Q slots and during I slots. A design that sampled these inputs on every edge would cut a pair short, and the result would be a Q slot with no I slot after it, or a byte routed to the wrong side. Inversion is toggled while both slot types pass, so a design that complemented I samples, or skipped the complement in transmit, shows a wrong byte. Stopping the stream exposes a DAC held at zero instead of mid-scale, or a stale byte left on the host output.

// File: rtl/iqb_pkg.sv
// Package: shared slot type and helpers for the I/Q interleaving bridge.
// Assumes: one slot per byte clock, two slots per converter sample.
package iqb_pkg;

    // Slot within a sample pair; Q always leads.
    typedef enum logic {
        SLOT_Q = 1'b0,
        SLOT_I = 1'b1
    } slot_e;

    // Complement a sample when inversion applies to a Q slot.
    function automatic logic [7:0] q_adjust(input logic [7:0] d, input slot_e s, input logic flip);
        return (flip && s == SLOT_Q) ? ~d : d;
    endfunction

endpackage

// File: rtl/iqb_sequencer.sv
// Module: slot sequencer. Tracks run state, direction and current slot.
// Assumes: direction and stream-off are taken only at pair boundaries
// (stream stopped, or the edge that ends an I slot).
module iqb_sequencer
    import iqb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stream_off_i,
    input  logic  tx_mode_i,
    output logic  run_o,
    output logic  tx_o,
    output slot_e slot_o
);

    logic boundary;

    // A pair boundary: idle, or the current slot is I.
    always_comb boundary = !run_o || (slot_o == SLOT_I);

    // Advance the slot, and take new controls at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o  <= 1'b0;
            tx_o   <= 1'b0;
            slot_o <= SLOT_Q;
        end else if (boundary) begin
            run_o  <= !stream_off_i;
            tx_o   <= tx_mode_i;
            slot_o <= SLOT_Q;
        end else begin
            slot_o <= SLOT_I;
        end
    end

endmodule

// File: rtl/iqb_lane.sv
// Module: one data lane (receive or transmit). Registers a byte, applies
// Q inversion and pads the low bits to OUT_W; drives an idle constant
// when not enabled (zero for receive, mid-scale for transmit).
// Assumes: OUT_W >= IN_W; IS_TX picks the idle value.
module iqb_lane
    import iqb_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10,
    parameter bit IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  slot_e            slot,
    input  logic             flip,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    localparam int PAD_W = OUT_W - IN_W;
    localparam logic [OUT_W-1:0] IDLE_VAL =
        IS_TX ? (OUT_W'(1) << (OUT_W - 1)) : '0;

    logic [IN_W-1:0]  adj;
    logic [OUT_W-1:0] word;

    // Apply Q inversion to the incoming byte.
    always_comb adj = q_adjust(din, slot, flip);

    // Place the byte in the upper bits; zero any low padding bits.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb word = {adj, {PAD_W{1'b0}}};
        end else begin : g_nopad
            always_comb word = adj;
        end
    endgenerate

    // Register the lane output, falling back to the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= IDLE_VAL;
        else if (en) dout <= word;
        else         dout <= IDLE_VAL;
    end

endmodule

// File: rtl/iqb_bridge.sv
// Module: I/Q interleaving bridge top. Sequences Q/I slots and routes
// bytes ADC->host or host->DAC with optional Q inversion.
// Assumes: clk runs at twice the converter rate; reset is synchronous.
module iqb_bridge
    import iqb_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DAC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode_i,
    input  logic              stream_off_i,
    input  logic              q_flip_i,
    input  logic [BYTE_W-1:0] adc_data_i,
    input  logic [BYTE_W-1:0] host_tx_i,
    output logic [BYTE_W-1:0] host_rx_o,
    output logic              rx_valid_o,
    output logic              slot_o,
    output logic [DAC_W-1:0]  dac_data_o
);

    logic  run_w;
    logic  tx_w;
    slot_e slot_w;
    logic  rx_en;
    logic  tx_en;

    iqb_sequencer seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .stream_off_i (stream_off_i),
        .tx_mode_i    (tx_mode_i),
        .run_o        (run_w),
        .tx_o         (tx_w),
        .slot_o       (slot_w)
    );

    // Lane enables from run state and direction.
    always_comb begin
        rx_en = run_w && !tx_w;
        tx_en = run_w && tx_w;
    end

    iqb_lane #(.IN_W(BYTE_W), .OUT_W(BYTE_W), .IS_TX(1'b0)) rx_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .slot  (slot_w),
        .flip  (q_flip_i),
        .din   (adc_data_i),
        .dout  (host_rx_o)
    );

    iqb_lane #(.IN_W(BYTE_W), .OUT_W(DAC_W), .IS_TX(1'b1)) tx_lane_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tx_en),
        .slot  (slot_w),
        .flip  (q_flip_i),
        .din   (host_tx_i),
        .dout  (dac_data_o)
    );

    // Qualifier and slot tag aligned with the lane outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o <= 1'b0;
            slot_o     <= 1'b0;
        end else begin
            rx_valid_o <= run_w;
            slot_o     <= (slot_w == SLOT_I);
        end
    end

endmodule

// File: rtl/iqb_bridge_chk.sv
// Module: assertion checker for iqb_bridge, attached by bind.
module iqb_bridge_chk #(
    parameter int BYTE_W = 8,
    parameter int DAC_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              tx,
    input logic              phase,
    input logic [BYTE_W-1:0] adc_data_i,
    input logic [BYTE_W-1:0] host_rx_o,
    input logic              rx_valid_o,
    input logic              slot_o,
    input logic [DAC_W-1:0]  dac_data_o
);

    localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

    // R2 R7
    pair_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && !slot_o) |=> (rx_valid_o && slot_o));

    // R2
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> !slot_o);

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> (dac_data_o == MID && host_rx_o == '0));

    // R4
    dac_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_data_o[1:0] == 2'b00);

    // R3
    rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tx && phase) |=> host_rx_o == $past(adc_data_i));

endmodule

bind iqb_bridge iqb_bridge_chk #(.BYTE_W(BYTE_W), .DAC_W(DAC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_w),
    .tx         (tx_w),
    .phase      (slot_w),
    .adc_data_i (adc_data_i),
    .host_rx_o  (host_rx_o),
    .rx_valid_o (rx_valid_o),
    .slot_o     (slot_o),
    .dac_data_o (dac_data_o)
);

// File: tb/iqb_bridge_tb.sv
module iqb_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_mode_i = 1'b0;
    logic       stream_off_i = 1'b1;
    logic       q_flip_i = 1'b0;
    logic [7:0] adc_data_i = '0;
    logic [7:0] host_tx_i = '0;
    logic [7:0] host_rx_o;
    logic       rx_valid_o;
    logic       slot_o;
    logic [9:0] dac_data_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // Reference state and expected outputs.
    bit       m_run = 0, m_tx = 0, m_ph = 0;
    bit       e_valid = 0, e_slot = 0, e_qf = 0;
    bit [7:0] e_rx = 0;
    bit [9:0] e_dac = 10'h200;

    always #2 clk = ~clk;

    iqb_bridge dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_mode_i    (tx_mode_i),
        .stream_off_i (stream_off_i),
        .q_flip_i     (q_flip_i),
        .adc_data_i   (adc_data_i),
        .host_tx_i    (host_tx_i),
        .host_rx_o    (host_rx_o),
        .rx_valid_o   (rx_valid_o),
        .slot_o       (slot_o),
        .dac_data_o   (dac_data_o)
    );

    function automatic bit [7:0] flip_of(bit [7:0] d, bit q);
        return q ? ~d : d;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model, stepped on each rising edge from the requirements.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_tx = 0; m_ph = 0;
            e_valid = 0; e_slot = 0; e_rx = 0; e_dac = 10'h200; e_qf = 0;
        end else begin
            e_valid = m_run;
            e_slot  = m_ph;
            e_qf    = q_flip_i && !m_ph;
            e_rx    = (m_run && !m_tx) ? flip_of(adc_data_i, e_qf) : 8'h00;
            e_dac   = (m_run && m_tx) ? {flip_of(host_tx_i, e_qf), 2'b00} : 10'h200;
            if (!m_run || m_ph) begin
                m_run = !stream_off_i; m_tx = tx_mode_i; m_ph = 0;
            end else begin
                m_ph = 1;
            end
        end
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check(!e_valid ? "R6" : (e_qf ? "R5" : "R3,R9"), host_rx_o, e_rx);
            check(!e_valid ? "R6" : (e_qf ? "R5" : "R4,R9"), dac_data_o, e_dac);
            check("R8", rx_valid_o, e_valid);
            check("R2,R7", slot_o, e_slot);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1bad5eed);
        step(3);
        rst_n = 1'b1;
        // R1 reset state, held stopped
        step(1);
        check("R1", host_rx_o, 0);
        check("R1", rx_valid_o, 0);
        check("R1", dac_data_o, 10'h200);
        check("R1", slot_o, 0);
        chk_en = 1'b1;

        // Receive stream with a fixed pattern (R3).
        stream_off_i = 1'b0;
        for (int i = 0; i < 12; i++) begin adc_data_i = 8'(i * 17 + 3); step(1); end
        // Q inversion in receive (R5).
        q_flip_i = 1'b1;
        for (int i = 0; i < 8; i++) begin adc_data_i = 8'hA5 ^ 8'(i); step(1); end
        // Direction change requested in mid-stream (R7, R9).
        step(1);
        tx_mode_i = 1'b1;
        host_tx_i = 8'h3C;
        step(1);
        host_tx_i = 8'hC3;
        step(6);
        // Transmit extremes (R4).
        q_flip_i = 1'b0;
        host_tx_i = 8'hFF; step(2);
        host_tx_i = 8'h00; step(2);
        // Stop during a pair (R6, R7).
        stream_off_i = 1'b1; step(1);
        stream_off_i = 1'b0; step(1);
        stream_off_i = 1'b1; step(4);
        // Reset during an active stream (R1).
        stream_off_i = 1'b0; step(5);
        rst_n = 1'b0; step(1);
        rst_n = 1'b1;
        check("R1", rx_valid_o, 0);
        check("R1", dac_data_o, 10'h200);
        step(2);

        // Constrained random mix.
        for (int i = 0; i < 4000; i++) begin
            adc_data_i   = 8'($urandom);
            host_tx_i    = 8'($urandom);
            q_flip_i     = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) tx_mode_i = ~tx_mode_i;
            if (($urandom % 20) == 0) stream_off_i = ~stream_off_i;
            step(1);
        end
        chk_en = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule